// File: doc/BRIEF.md
# Input Shift Register with Automatic Push

This block is the receive-side shift register of a programmable I/O state machine. The sequencer issues shift-in commands of 1 to 32 bits. Each command takes its bits either from a data word, which is normally the sampled pins, or from a zero source. The existing contents move left or right to make room for the new bits, as a configuration bit selects. A saturating counter records how many bits have entered since the register was last emptied.

The register is handed to an RX FIFO through a registered valid/ready write port. A hand-off starts in one of three ways:

- an explicit push;
- a conditional push, which goes ahead only once the counter has reached a configured threshold;
- an automatic push, which fires during a shift-in when automatic push is enabled and the threshold is reached.

When the FIFO accepts the word, the register and the counter are cleared. While the FIFO refuses the word, the block raises a stall flag and holds its state. Direct writes from the sequencer and from the output-shift path load the register, and a restart input clears it.

Shifting right and then adding zero bits from the zero source turns a serial stream that arrives least-significant bit first into a right-aligned word.

Top module: `isr_autopush`

## Requirements
- R1: With `cfg_shift_right`=0, a shift-in of n bits gives the result (old << n) | low n bits of the source. Bit 0 receives source bit 0.
- R2: With `cfg_shift_right`=1, a shift-in of n bits gives (old >> n), with source bits [n-1:0] placed in result bits [31:32-n].
- R3: A push presents the register value on `fifo_data` with `fifo_valid`=1 one cycle after the command. On the cycle in which `fifo_ready`=1 is seen, the word is taken, and the register and `shift_cnt` both become 0.
- R4: Each shift-in adds n to `shift_cnt`, and the sum saturates at 32.
- R5: With `cfg_autopush`=1, a shift-in that brings `shift_cnt` to or above the threshold also pushes the word that results from that shift.
- R6: A push with `push_if_full`=1 and `shift_cnt` below the threshold does nothing. At or above the threshold, it pushes as in R3.
- R7: Reset and `restart` clear the register, clear `shift_cnt` and drop `fifo_valid`.
- R8: `wr_valid` loads `wr_data` and clears `shift_cnt`. `osr_valid` loads `osr_data` and sets `shift_cnt` to `osr_count`.
- R9: With `in_src`=1 (the zero source), the shift-in adds n zero bits and ignores `in_data`.
- R10: Count and threshold fields use 0 to mean 32. This applies to `in_count`, `osr_count` and `cfg_thresh`.
- R11: While `fifo_valid`=1 and `fifo_ready`=0, `stall`=1, and the following are held: `fifo_data`, the register and `shift_cnt`. Every command except `restart` is ignored while a word is pending.
- R12: If several commands arrive in one cycle, only one takes effect, in this priority order: restart, `wr_valid`, `osr_valid`, `push_valid`, `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Clears register, counter and pending word |
| cfg_shift_right | input | 1 | 1: shift right, new bits enter at the top |
| cfg_autopush | input | 1 | Enables the automatic push |
| cfg_thresh | input | 5 | Push threshold in bits (0 means 32) |
| in_valid | input | 1 | Shift-in command |
| in_src | input | 1 | 0: take bits from in_data, 1: zero source |
| in_data | input | 32 | Source bits, least significant first |
| in_count | input | 5 | Bits to shift (0 means 32) |
| push_valid | input | 1 | Push command |
| push_if_full | input | 1 | Makes the push depend on the threshold |
| wr_valid | input | 1 | Direct register write |
| wr_data | input | 32 | Direct write value |
| osr_valid | input | 1 | Write from the output-shift path |
| osr_data | input | 32 | Value from the output-shift path |
| osr_count | input | 5 | Counter value for that write (0 means 32) |
| fifo_ready | input | 1 | FIFO can accept a word |
| fifo_valid | output | 1 | Word pending for the FIFO |
| fifo_data | output | 32 | Word to the FIFO |
| stall | output | 1 | A pending word is being refused |
| isr_value | output | 32 | Current register contents |
| shift_cnt | output | 6 | Bits shifted in, 0 to 32 |

## Verification
A wrong counter value shows up first on `shift_cnt` in the cycle after the command that set it. A few commands later, it shows as an automatic or conditional push that fires one shift too early or too late, so the scoreboard then receives a word it did not expect, or misses one. A fault in the shift path or the direction select appears on `isr_value` one cycle after the shift, and appears again in the pushed word. A fault in the hold logic shows as a change on `isr_value` or `shift_cnt` during a stall, or as a lost or duplicated FIFO word.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned ISR_W = 32;
  typedef enum logic {SRC_DATA = 1'b0, SRC_ZERO = 1'b1} isr_src_e;
endpackage

// File: rtl/isr_shifter.sv
module isr_shifter #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] n,
  input  logic          right,
  output logic [W-1:0]  nxt
);
  logic [W-1:0]  mask;
  logic [CW-1:0] rem;

  // bit i of the source survives when i < n
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (CW'(i) < n);
  end

  assign rem = CW'(W) - n;

  always_comb begin
    if (n >= CW'(W))
      nxt = din;
    else if (right)
      nxt = (cur >> n) | ((din & mask) << rem);
    else
      nxt = (cur << n) | (din & mask);
  end
endmodule

// File: rtl/isr_counter.sv
module isr_counter #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          set_en,
  input  logic [CW-1:0] set_val,
  input  logic          add_en,
  input  logic [CW-1:0] add_val,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] cnt,
  output logic          reached,
  output logic          add_reached
);
  logic [CW:0]   sum;
  logic [CW-1:0] sat;

  assign sum = {1'b0, cnt} + {1'b0, add_val};
  assign sat = (sum > (CW+1)'(W)) ? CW'(W) : sum[CW-1:0];
  assign reached     = (cnt >= thr);
  assign add_reached = (sat >= thr);

  always_ff @(posedge clk) begin
    if (clr)         cnt <= '0;
    else if (set_en) cnt <= set_val;
    else if (add_en) cnt <= sat;
  end
endmodule

// File: rtl/isr_autopush.sv
module isr_autopush
  import isr_pkg::*;
#(
  parameter int unsigned W  = ISR_W,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned NW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          cfg_shift_right,
  input  logic          cfg_autopush,
  input  logic [NW-1:0] cfg_thresh,
  input  logic          in_valid,
  input  logic          in_src,
  input  logic [W-1:0]  in_data,
  input  logic [NW-1:0] in_count,
  input  logic          push_valid,
  input  logic          push_if_full,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          osr_valid,
  input  logic [W-1:0]  osr_data,
  input  logic [NW-1:0] osr_count,
  input  logic          fifo_ready,
  output logic          fifo_valid,
  output logic [W-1:0]  fifo_data,
  output logic          stall,
  output logic [W-1:0]  isr_value,
  output logic [CW-1:0] shift_cnt
);
  logic [W-1:0]  isr_q, src_bits, shifted;
  logic [CW-1:0] n_in, n_osr, thr;
  logic          busy, accept, push_go, reached, add_reached;
  logic          cnt_clr, cnt_set, cnt_add;

  function automatic logic [CW-1:0] decode_cnt(input logic [NW-1:0] f);
    return (f == '0) ? CW'(W) : CW'(f);
  endfunction

  assign n_in     = decode_cnt(in_count);
  assign n_osr    = decode_cnt(osr_count);
  assign thr      = decode_cnt(cfg_thresh);
  assign src_bits = (isr_src_e'(in_src) == SRC_ZERO) ? '0 : in_data;

  assign busy    = fifo_valid;
  assign accept  = fifo_valid & fifo_ready;
  assign push_go = push_valid & (~push_if_full | reached);

  assign cnt_clr = rst | restart | accept | (~busy & wr_valid);
  assign cnt_set = ~busy & ~wr_valid & osr_valid;
  assign cnt_add = ~busy & ~wr_valid & ~osr_valid & ~push_valid & in_valid;

  isr_shifter #(.W(W)) u_shift (
    .cur   (isr_q),
    .din   (src_bits),
    .n     (n_in),
    .right (cfg_shift_right),
    .nxt   (shifted)
  );

  isr_counter #(.W(W)) u_cnt (
    .clk         (clk),
    .clr         (cnt_clr),
    .set_en      (cnt_set),
    .set_val     (n_osr),
    .add_en      (cnt_add),
    .add_val     (n_in),
    .thr         (thr),
    .cnt         (shift_cnt),
    .reached     (reached),
    .add_reached (add_reached)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      isr_q      <= '0;
      fifo_valid <= 1'b0;
      fifo_data  <= '0;
    end else if (busy) begin
      if (accept) begin
        isr_q      <= '0;
        fifo_valid <= 1'b0;
      end
    end else if (wr_valid) begin
      isr_q <= wr_data;
    end else if (osr_valid) begin
      isr_q <= osr_data;
    end else if (push_valid) begin
      if (push_go) begin
        fifo_valid <= 1'b1;
        fifo_data  <= isr_q;
      end
    end else if (in_valid) begin
      isr_q <= shifted;
      if (cfg_autopush && add_reached) begin
        fifo_valid <= 1'b1;
        fifo_data  <= shifted;
      end
    end
  end

  assign isr_value = isr_q;
  assign stall     = fifo_valid & ~fifo_ready;
endmodule

// File: rtl/isr_autopush_chk.sv
module isr_autopush_chk #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned NW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          restart,
  input logic [NW-1:0] cfg_thresh,
  input logic          push_valid,
  input logic          push_if_full,
  input logic          wr_valid,
  input logic          osr_valid,
  input logic          fifo_ready,
  input logic          fifo_valid,
  input logic [W-1:0]  fifo_data,
  input logic          stall,
  input logic [W-1:0]  isr_value,
  input logic [CW-1:0] shift_cnt
);
  logic [CW-1:0] thr_c;
  assign thr_c = (cfg_thresh == '0) ? CW'(W) : CW'(cfg_thresh);

  // R4: counter never exceeds the register width
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    shift_cnt <= CW'(W));

  // R11: a refused word and the state behind it stay put
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !restart) |=> (fifo_valid && $stable(fifo_data)
                              && $stable(isr_value) && $stable(shift_cnt)));

  // R3: acceptance empties the register and the counter
  a_r3_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
    (fifo_valid && fifo_ready && !restart) |=>
      (!fifo_valid && isr_value == '0 && shift_cnt == '0));

  // R7: restart clears counter and pending word
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!fifo_valid && shift_cnt == '0 && isr_value == '0));

  // R6: conditional push below threshold starts nothing
  a_r6_cond_blocked: assert property (@(posedge clk) disable iff (rst)
    (!fifo_valid && push_valid && push_if_full && shift_cnt < thr_c
     && !restart && !wr_valid && !osr_valid) |=> !fifo_valid);
endmodule

bind isr_autopush isr_autopush_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .cfg_thresh(cfg_thresh),
  .push_valid(push_valid), .push_if_full(push_if_full),
  .wr_valid(wr_valid), .osr_valid(osr_valid), .fifo_ready(fifo_ready),
  .fifo_valid(fifo_valid), .fifo_data(fifo_data), .stall(stall),
  .isr_value(isr_value), .shift_cnt(shift_cnt)
);

// File: tb/isr_autopush_tb.sv
module isr_autopush_tb;
  logic clk = 0, rst = 1, restart = 0;
  logic cfg_shift_right = 0, cfg_autopush = 0;
  logic [4:0] cfg_thresh = 0;
  logic in_valid = 0, in_src = 0;
  logic [31:0] in_data = 0;
  logic [4:0] in_count = 0;
  logic push_valid = 0, push_if_full = 0, wr_valid = 0, osr_valid = 0;
  logic [31:0] wr_data = 0, osr_data = 0;
  logic [4:0] osr_count = 0;
  logic fifo_ready = 1;
  logic fifo_valid, stall;
  logic [31:0] fifo_data, isr_value;
  logic [5:0] shift_cnt;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] m_isr = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  isr_autopush u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops expected words as the FIFO takes them (R3, R5, R6)
  always @(negedge clk) begin
    if (!rst && fifo_valid && fifo_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected word", fifo_data, 32'hx);
      else chk("R3 fifo word", fifo_data, exp_q.pop_front());
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

  function automatic int eff(logic [4:0] f); return (f == 0) ? 32 : int'(f); endfunction

  task automatic do_shift(bit zero, logic [31:0] d, logic [4:0] cf);
    int n = eff(cf);
    logic [31:0] s = zero ? 32'h0 : d;
    for (int i = 0; i < n; i++)
      if (cfg_shift_right) m_isr = {s[i], m_isr[31:1]};
      else                 m_isr = {m_isr[30:0], s[n-1-i]};
    m_cnt = (m_cnt + n > 32) ? 32 : m_cnt + n;
    if (cfg_autopush && m_cnt >= eff(cfg_thresh)) begin
      exp_q.push_back(m_isr); m_isr = 0; m_cnt = 0;
    end
    in_valid = 1; in_src = zero; in_data = d; in_count = cf;
    step();
    in_valid = 0;
  endtask

  task automatic do_push(bit cond);
    if (!cond || m_cnt >= eff(cfg_thresh)) begin
      exp_q.push_back(m_isr); m_isr = 0; m_cnt = 0;
    end
    push_valid = 1; push_if_full = cond;
    step();
    push_valid = 0; push_if_full = 0;
  endtask

  task automatic look(string req);
    @(negedge clk);
    chk({req, " isr"}, isr_value, m_isr);
    chk({req, " cnt"}, {26'd0, shift_cnt}, m_cnt);
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin : main
    logic [31:0] held;
    idle(3); rst = 0;
    @(negedge clk);
    // R7 reset state
    chk("R7 reset isr", isr_value, 0);
    chk("R7 reset cnt", {26'd0, shift_cnt}, 0);
    chk("R7 reset valid", {31'd0, fifo_valid}, 0);
    step();

    // R1 left shifts, R4 accumulation
    do_shift(0, 32'hFFFF_FFA5, 5'd8); look("R1");
    do_shift(0, 32'h0000_0003, 5'd4);
    @(negedge clk); chk("R1 literal", isr_value, 32'h0000_0A53); step();
    look("R4");
    // R3 explicit push
    do_push(0); idle(2); look("R3");

    // R2 right shift, R9 zero fill for right alignment
    cfg_shift_right = 1;
    do_shift(0, 32'h0000_005A, 5'd8);
    @(negedge clk); chk("R2 literal", isr_value, 32'h5A00_0000); step();
    do_shift(0, 32'hFFFF_FFFF, 5'd24);
    do_shift(1, 32'hFFFF_FFFF, 5'd24);
    look("R9");
    // R4 saturation
    do_shift(1, 0, 5'd16); look("R4 sat");

    // R8 direct write, R10 count 0 means 32
    wr_valid = 1; wr_data = 32'hDEAD_BEEF; m_isr = wr_data; m_cnt = 0;
    step(); wr_valid = 0; look("R8 wr");
    cfg_shift_right = 0;
    do_shift(0, 32'h1234_5678, 5'd0); look("R10");
    osr_valid = 1; osr_data = 32'hCAFE_0001; osr_count = 5'd5;
    m_isr = osr_data; m_cnt = 5; step(); osr_valid = 0; look("R8 osr");

    // R6 conditional push
    cfg_thresh = 5'd16;
    do_push(1); idle(1);
    @(negedge clk); chk("R6 blocked", {31'd0, fifo_valid}, 0); step();
    look("R6 blocked");
    do_shift(0, 32'h0000_0ABC, 5'd12);
    do_push(1); idle(2); look("R6 go");

    // R5 autopush at threshold
    cfg_autopush = 1;
    do_shift(0, 32'h0000_00C3, 5'd8); look("R5 below");
    do_shift(0, 32'h0000_003C, 5'd8); idle(1); look("R5 fired");
    cfg_autopush = 0;

    // R11 stall and hold
    do_shift(0, 32'h0000_0077, 5'd7);
    fifo_ready = 0; held = m_isr;
    do_push(0); idle(3);
    @(negedge clk);
    chk("R11 stall", {31'd0, stall}, 1);
    chk("R11 isr held", isr_value, held);
    chk("R11 cnt held", {26'd0, shift_cnt}, 7);
    step();
    in_valid = 1; in_data = 32'hF; in_count = 5'd4; step(); in_valid = 0;
    @(negedge clk);
    chk("R11 ignored isr", isr_value, held);
    chk("R11 ignored cnt", {26'd0, shift_cnt}, 7);
    step();
    fifo_ready = 1; idle(2); look("R11 release");

    // R12 priority: write beats shift in the same cycle
    wr_valid = 1; wr_data = 32'h0000_1111; in_valid = 1; in_count = 5'd3;
    m_isr = wr_data; m_cnt = 0;
    step(); wr_valid = 0; in_valid = 0; look("R12");

    // R7 restart
    do_shift(0, 32'h5, 5'd3);
    restart = 1; m_isr = 0; m_cnt = 0; step(); restart = 0; look("R7 restart");

    idle(2);
    chk("R3 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule